// File: doc/BRIEF.md
# Rate-Multiplied Character De-Stuffer

This block sits behind a three-lane character receiver whose link clock is held in a fixed frequency band while the pixel rate varies. To cover lower pixel rates the sender repeats a fixed filler character after each data character, so that only one link-clock slot in a group carries a pixel. The block takes one 10-bit character per lane on every link clock, together with a rate-mode setting that gives the group length (1, 2 or 4 slots). It emits one 30-bit character triple per pixel with a valid strobe.

The block locks the group phase from the character stream. In grouped modes, the first non-filler character on lane 0 that follows a filler on lane 0 is taken as the data slot. From then on the block counts slots. It passes the data slot and drops the filler slots. A filler slot that holds any other code is a framing fault. A fault raises a sticky error flag and sends the block back to the unaligned state. A change of rate mode also forces a new lock. In single-slot mode there is no filler, and every character is forwarded.

Top module: `char_destuff`

## Requirements
- R1: While reset is asserted (rst_n low), pix_valid, stuff_err and aligned are all 0.
- R2: With rate_mode 0 (single-slot; code 3 behaves the same), when the mode is unchanged from the previous clock, every input triple appears on pix_chars with pix_valid high one clock later, filler codes included.
- R3: With rate_mode 1 (two-slot), a data slot is followed by exactly one filler slot, and each data triple is forwarded one clock after it is sampled.
- R4: With rate_mode 2 (four-slot), a data slot is followed by exactly three filler slots, so pix_valid is never high on two consecutive clocks in a grouped mode.
- R5: While unaligned in a grouped mode, pix_valid stays low. Lock happens only on a lane-0 non-filler character whose predecessor on lane 0 was the filler. That locking character is itself forwarded, and aligned rises.
- R6: If a filler slot holds a non-filler code on any lane, no pixel is emitted, stuff_err becomes 1, and aligned drops to 0 on the next clock. Relock then follows the R5 rule.
- R7: Once set, stuff_err stays 1 until reset.
- R8: On a clock where rate_mode differs from its value on the previous clock, no pixel is emitted and aligned is 0 afterwards. The value held during reset counts as mode 0.
- R9: The filler code is 10'h07A (binary 0001111010, bit 9 leftmost). Lane 0 occupies bits [9:0] of the triple, lane 1 occupies [19:10], and lane 2 occupies [29:20].
- R10: Forwarded triples are bit-exact copies of the data-slot input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_mode | input | 2 | Slots per pixel: 0 = one, 1 = two, 2 = four, 3 = one |
| lane_chars | input | 30 | One character per lane; lane 0 in bits [9:0] |
| pix_chars | output | 30 | Forwarded data triple |
| pix_valid | output | 1 | High for one clock per forwarded pixel |
| stuff_err | output | 1 | Sticky flag: a filler slot held another code |
| aligned | output | 1 | The group phase is locked |

## Verification
A wrong slot phase shows within one group: a filler triple appears on pix_chars with pix_valid high, or a valid data character is lost, at most four clocks after the slip. A lock taken on the wrong character makes every later pixel a shifted copy. The bench therefore compares each strobe against the exact triple expected for that slot. A missed mode change or a missed error shows on aligned and stuff_err one clock after the offending input, before any later pixel can hide it.

// File: rtl/destuff_pkg.sv
package destuff_pkg;

  typedef enum logic [1:0] {
    RATE_1X   = 2'd0,
    RATE_2X   = 2'd1,
    RATE_4X   = 2'd2,
    RATE_ALT1 = 2'd3
  } rate_e;

  // Slots per pixel group for a rate setting.
  function automatic logic [2:0] group_len(input logic [1:0] mode);
    case (mode)
      2'd1:    group_len = 3'd2;
      2'd2:    group_len = 3'd4;
      default: group_len = 3'd1;
    endcase
  endfunction

  // Slot index that follows ph inside a group of glen slots.
  function automatic logic [1:0] next_slot(input logic [1:0] ph, input logic [2:0] glen);
    logic [2:0] n;
    n = {1'b0, ph} + 3'd1;
    next_slot = (n >= glen) ? 2'd0 : n[1:0];
  endfunction

endpackage

// File: rtl/lane_fill_detect.sv
module lane_fill_detect #(
  parameter int CHAR_W = 10,
  parameter int LANES  = 3,
  parameter logic [CHAR_W-1:0] FILL_CODE = 10'h07A
) (
  input  logic [CHAR_W*LANES-1:0] chars,
  output logic [LANES-1:0]        is_fill
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign is_fill[g] = (chars[g*CHAR_W +: CHAR_W] == FILL_CODE);
  end
endmodule

// File: rtl/slot_tracker.sv
module slot_tracker #(
  parameter int LANES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rate_mode,
  input  logic [LANES-1:0] is_fill,
  output logic             emit,
  output logic             err_evt,
  output logic             mode_chg,
  output logic             aligned,
  output logic             stuff_err
);
  import destuff_pkg::*;

  logic [1:0] mode_q;
  logic [1:0] phase_q, phase_d;
  logic       aligned_d;
  logic       prev_fill0_q;
  logic [2:0] glen;
  logic       lock_ok;

  assign glen     = group_len(rate_mode);
  assign mode_chg = (rate_mode != mode_q);
  assign lock_ok  = (glen == 3'd1) || (prev_fill0_q && !is_fill[0]);

  always_comb begin
    emit      = 1'b0;
    err_evt   = 1'b0;
    aligned_d = aligned;
    phase_d   = phase_q;
    if (mode_chg) begin
      aligned_d = 1'b0;
      phase_d   = 2'd0;
    end else if (!aligned) begin
      if (lock_ok) begin
        emit      = 1'b1;
        aligned_d = 1'b1;
        phase_d   = next_slot(2'd0, glen);
      end
    end else if (phase_q == 2'd0) begin
      emit    = 1'b1;
      phase_d = next_slot(2'd0, glen);
    end else if (!(&is_fill)) begin
      err_evt   = 1'b1;
      aligned_d = 1'b0;
      phase_d   = 2'd0;
    end else begin
      phase_d = next_slot(phase_q, glen);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= RATE_1X;
      phase_q      <= 2'd0;
      aligned      <= 1'b0;
      prev_fill0_q <= 1'b0;
      stuff_err    <= 1'b0;
    end else begin
      mode_q       <= rate_mode;
      phase_q      <= phase_d;
      aligned      <= aligned_d;
      prev_fill0_q <= is_fill[0];
      if (err_evt) stuff_err <= 1'b1;
    end
  end

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |=> stuff_err);
  a_r6_err_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> (stuff_err && !aligned));
  a_r8_mode_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !aligned);
  a_r4_phase_in_group: assert property (@(posedge clk) disable iff (!rst_n)
    aligned |-> ({1'b0, phase_q} < group_len(mode_q)));
endmodule

// File: rtl/pixel_reg.sv
module pixel_reg #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         emit,
  input  logic [W-1:0] data_in,
  output logic         pix_valid,
  output logic [W-1:0] pix_chars
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_chars <= '0;
    end else begin
      pix_valid <= emit;
      if (emit) pix_chars <= data_in;
    end
  end

  a_r10_data_copy: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> (pix_valid && pix_chars == $past(data_in)));
endmodule

// File: rtl/char_destuff.sv
module char_destuff #(
  parameter int CHAR_W = 10,
  parameter int LANES  = 3,
  parameter logic [CHAR_W-1:0] FILL_CODE = 10'h07A
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              rate_mode,
  input  logic [CHAR_W*LANES-1:0] lane_chars,
  output logic [CHAR_W*LANES-1:0] pix_chars,
  output logic                    pix_valid,
  output logic                    stuff_err,
  output logic                    aligned
);
  import destuff_pkg::*;

  localparam int TRIPLE_W = CHAR_W * LANES;

  logic [LANES-1:0] is_fill;
  logic             emit;
  logic             err_evt;
  logic             mode_chg;

  lane_fill_detect #(.CHAR_W(CHAR_W), .LANES(LANES), .FILL_CODE(FILL_CODE)) u_fill (
    .chars   (lane_chars),
    .is_fill (is_fill)
  );

  slot_tracker #(.LANES(LANES)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_mode (rate_mode),
    .is_fill   (is_fill),
    .emit      (emit),
    .err_evt   (err_evt),
    .mode_chg  (mode_chg),
    .aligned   (aligned),
    .stuff_err (stuff_err)
  );

  pixel_reg #(.W(TRIPLE_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .emit      (emit),
    .data_in   (lane_chars),
    .pix_valid (pix_valid),
    .pix_chars (pix_chars)
  );

  a_r5_valid_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> aligned);
  a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && group_len(rate_mode) != 3'd1) |=> !pix_valid);
  a_r2_every_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_chg && group_len(rate_mode) == 3'd1) |=> pix_valid);
  a_r8_no_pixel_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !pix_valid);
endmodule

// File: tb/char_destuff_tb.sv
module char_destuff_tb;
  localparam logic [9:0]  FILL = 10'h07A;
  localparam logic [29:0] F3   = {FILL, FILL, FILL};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rate_mode = 2'd0;
  logic [29:0] lane_chars = '0;
  logic [29:0] pix_chars;
  logic        pix_valid, stuff_err, aligned;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  char_destuff u_dut (
    .clk(clk), .rst_n(rst_n), .rate_mode(rate_mode), .lane_chars(lane_chars),
    .pix_chars(pix_chars), .pix_valid(pix_valid), .stuff_err(stuff_err), .aligned(aligned)
  );

  function automatic logic [29:0] mk(input logic [9:0] l0, input logic [9:0] l1, input logic [9:0] l2);
    return {l2, l1, l0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one triple at a falling edge; inspect the result one clock later.
  task automatic step(input string req, input logic [29:0] ch, input logic ev, input logic [29:0] ed);
    lane_chars = ch;
    @(posedge clk);
    @(negedge clk);
    chk({req, " valid"}, {31'd0, pix_valid}, {31'd0, ev});
    if (ev) chk({req, " data"}, {2'd0, pix_chars}, {2'd0, ed});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 valid", {31'd0, pix_valid}, 32'd0);
    chk("R1 err", {31'd0, stuff_err}, 32'd0);
    chk("R1 aligned", {31'd0, aligned}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_single();
    rate_mode = 2'd0;
    step("R2 first", mk(10'h101, 10'h202, 10'h303), 1, mk(10'h101, 10'h202, 10'h303));
    step("R2 filler kept", F3, 1, F3);
    step("R10 next", mk(10'h3FF, 10'h000, 10'h155), 1, mk(10'h3FF, 10'h000, 10'h155));
    chk("R2 aligned", {31'd0, aligned}, 32'd1);
  endtask

  task automatic t_two();
    rate_mode = 2'd1;
    step("R8 change", mk(10'h111, 10'h112, 10'h113), 0, '0);
    step("R5 no lock", mk(10'h121, 10'h122, 10'h123), 0, '0);
    step("R5 filler", F3, 0, '0);
    step("R3 lock", mk(10'h131, 10'h132, 10'h133), 1, mk(10'h131, 10'h132, 10'h133));
    chk("R5 aligned", {31'd0, aligned}, 32'd1);
    step("R3 drop", F3, 0, '0);
    step("R3 data", mk(10'h141, 10'h142, 10'h143), 1, mk(10'h141, 10'h142, 10'h143));
    step("R3 drop2", F3, 0, '0);
  endtask

  task automatic t_four();
    rate_mode = 2'd2;
    step("R8 change4", F3, 0, '0);
    step("R9 lock4", mk(10'h151, 10'h152, 10'h153), 1, mk(10'h151, 10'h152, 10'h153));
    for (int i = 0; i < 3; i++) step("R4 drop", F3, 0, '0);
    step("R4 data", mk(10'h161, 10'h162, 10'h163), 1, mk(10'h161, 10'h162, 10'h163));
    for (int i = 0; i < 3; i++) step("R4 drop", F3, 0, '0);
    step("R4 data2", mk(10'h171, 10'h172, 10'h173), 1, mk(10'h171, 10'h172, 10'h173));
    chk("R6 clean", {31'd0, stuff_err}, 32'd0);
  endtask

  task automatic t_error();
    step("R6 pre", F3, 0, '0);
    step("R6 bad lane2", mk(FILL, FILL, 10'h0AA), 0, '0);
    chk("R6 err", {31'd0, stuff_err}, 32'd1);
    chk("R6 unaligned", {31'd0, aligned}, 32'd0);
    step("R6 relock", mk(10'h181, 10'h182, 10'h183), 1, mk(10'h181, 10'h182, 10'h183));
    for (int i = 0; i < 3; i++) step("R4 drop", F3, 0, '0);
    step("R6 data", mk(10'h191, 10'h192, 10'h193), 1, mk(10'h191, 10'h192, 10'h193));
    chk("R7 sticky", {31'd0, stuff_err}, 32'd1);
  endtask

  task automatic t_mode();
    rate_mode = 2'd0;
    step("R8 to single", mk(10'h1A1, 10'h1A2, 10'h1A3), 0, '0);
    chk("R8 unaligned", {31'd0, aligned}, 32'd0);
    step("R2 after change", mk(10'h1B1, 10'h1B2, 10'h1B3), 1, mk(10'h1B1, 10'h1B2, 10'h1B3));
    chk("R7 still", {31'd0, stuff_err}, 32'd1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_two();
    t_four();
    t_error();
    t_mode();
    finish_run();
  end
endmodule